// File: doc/BRIEF.md
# Dual-Resolution PWM Tuning DAC

This block turns a 14-bit tuning word into one pulse-width modulated output line that an external RC low-pass filter smooths into a tuning voltage. A free-running 14-bit counter splits its 16384-clock cycle into 128 sub-periods of 128 clocks each. The upper 7 bits of the word (coarse) set the duty cycle that repeats in every sub-period. The lower 7 bits (fine) add single-clock pulses that are spread evenly over the sub-periods. This gives 16384 output levels while the ripple stays at the sub-period rate.

Software writes the coarse latch first and the fine latch second. The fine write arms a transfer: both latches are copied into the working register at the next sub-period boundary, so a half-written word never reaches the output. After reset the output rests at its inactive level until the first transfer. A polarity input selects the output sense.

Top module: `tdac_pwm`

## Requirements
- R1: The counter starts at 0 in the first clock after reset release and then advances by one every clock, wrapping after 16384 clocks. The sub-period index is counter bits [13:7] and the position inside the sub-period is bits [6:0]. The output is registered: after the k-th rising edge following reset release, `tdac_o` shows the state for counter value k-1 (mod 16384).
- R2: With normal polarity and coarse value C, the output is low at positions 0..C-1 of every sub-period and high at positions C..127.
- R3: Fine bits are active-low. A zero in fine bit b (bit 0 is the LSB) forces the output high at position 0 of every nonzero sub-period k whose number of trailing zero bits equals 6-b. Several zero bits combine their sets: fine 7'b1111010 adds pulses in sub-periods 16, 48, 64, 80 and 112.
- R4: Sub-period 0 never carries a fine pulse.
- R5: With normal polarity, committed coarse C and fine F, every 16384-clock window holds 128*(128-C) high clocks plus (127-F) more when C is nonzero.
- R6: A coarse write on its own leaves the output waveform unchanged. A fine write copies both latches into the working register at the edge where the counter position is 127, for the first such edge at or after the write. The new word governs the output from position 0 of the next sub-period onward.
- R7: `pol_i`=1 gives the normal sense and `pol_i`=0 inverts the output, so the high count over a full cycle becomes 16384 minus the R5 value.
- R8: Reset sets both latches to all ones and clears the counter and the output. Until the first transfer, the output stays at its inactive level: low when `pol_i`=1 and high when `pol_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock, one t0 per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coarse_wr_i | input | 1 | Write strobe for the coarse latch |
| coarse_data_i | input | 7 | Coarse value |
| fine_wr_i | input | 1 | Write strobe for the fine latch; arms the transfer |
| fine_data_i | input | 7 | Fine value, active-low bits |
| pol_i | input | 1 | Output sense: 1 normal, 0 inverted |
| tdac_o | output | 1 | PWM output |

## Verification
The bench follows the block's counter by counting clock edges from reset release. It writes a word in the middle of a sub-period and checks that the output stays idle in the last clock before the boundary and changes in the first clock after it. A design that commits at the write itself, or one sub-period late, fails this check. It scans a whole cycle for the 1111010 fine pattern, checking positions 0 and 1 of every sub-period; an error in the trailing-zero decoding, or a stray pulse in sub-period 0, shows up as a wrong sub-period. Full-cycle high counts are compared against the closed-form total for random words and for the end cases: coarse 0, where fine pulses must vanish into the high level, and coarse 127 with all fine bits zero. The bench also checks that a coarse-only write changes nothing and that an inverted output gives the complementary count.

// File: rtl/tdac_pkg.sv
package tdac_pkg;
  localparam int unsigned SUB_W_DEF = 7;
endpackage

// File: rtl/tdac_counter.sv
module tdac_counter #(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned POS_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sub_end_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign sub_end_o = &cnt_q[POS_W-1:0];

  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_cnt_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1) |=> (cnt_q == '0));
endmodule

// File: rtl/tdac_latches.sv
module tdac_latches #(
  parameter int unsigned SUB_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             coarse_wr_i,
  input  logic [SUB_W-1:0] coarse_data_i,
  input  logic             fine_wr_i,
  input  logic [SUB_W-1:0] fine_data_i,
  input  logic             sub_end_i,
  output logic [SUB_W-1:0] work_coarse_o,
  output logic [SUB_W-1:0] work_fine_o,
  output logic             armed_o
);
  logic [SUB_W-1:0] coarse_q, fine_q, coarse_nxt, fine_nxt;
  logic [SUB_W-1:0] wcoarse_q, wfine_q;
  logic             pend_q, armed_q, commit;

  assign coarse_nxt = coarse_wr_i ? coarse_data_i : coarse_q;
  assign fine_nxt   = fine_wr_i   ? fine_data_i   : fine_q;
  // a fine write landing on the boundary clock commits at once
  assign commit     = sub_end_i & (pend_q | fine_wr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coarse_q  <= '1;
      fine_q    <= '1;
      wcoarse_q <= '1;
      wfine_q   <= '1;
      pend_q    <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      coarse_q <= coarse_nxt;
      fine_q   <= fine_nxt;
      if (commit) begin
        wcoarse_q <= coarse_nxt;
        wfine_q   <= fine_nxt;
        armed_q   <= 1'b1;
        pend_q    <= 1'b0;
      end else if (fine_wr_i) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign work_coarse_o = wcoarse_q;
  assign work_fine_o   = wfine_q;
  assign armed_o       = armed_q;

  p_hold_off_boundary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_end_i |=> ($stable(wcoarse_q) && $stable(wfine_q)));
  p_commit_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_end_i && (pend_q || fine_wr_i)) |=> (armed_q && !pend_q));
  p_no_arm_without_fine_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !pend_q && !fine_wr_i) |=> !armed_q);
endmodule

// File: rtl/tdac_pulse.sv
module tdac_pulse #(
  parameter int unsigned SUB_W = 7,
  localparam int unsigned CNT_W = 2 * SUB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SUB_W-1:0] coarse_i,
  input  logic [SUB_W-1:0] fine_i,
  output logic             raw_o
);
  logic [SUB_W-1:0] pos, sub_idx, hit;
  logic             coarse_hi, fine_hi;

  assign pos     = cnt_i[SUB_W-1:0];
  assign sub_idx = cnt_i[CNT_W-1:SUB_W];

  // fine bit b owns sub-periods whose lowest set bit is SUB_W-1-b
  for (genvar b = 0; b < SUB_W; b++) begin : g_fine
    localparam int unsigned P = SUB_W - 1 - b;
    if (P == 0) begin : g_lsb
      assign hit[b] = sub_idx[0] & ~fine_i[b];
    end else begin : g_upper
      assign hit[b] = sub_idx[P] & ~(|sub_idx[P-1:0]) & ~fine_i[b];
    end
  end

  assign coarse_hi = (pos >= coarse_i);
  assign fine_hi   = (pos == '0) & (|hit);
  assign raw_o     = coarse_hi | fine_hi;

  p_fine_one_owner_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
  p_no_fine_sub0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_idx == '0) |-> (hit == '0));
endmodule

// File: rtl/tdac_pwm.sv
module tdac_pwm #(
  parameter int unsigned SUB_W = tdac_pkg::SUB_W_DEF,
  localparam int unsigned CNT_W = 2 * SUB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             coarse_wr_i,
  input  logic [SUB_W-1:0] coarse_data_i,
  input  logic             fine_wr_i,
  input  logic [SUB_W-1:0] fine_data_i,
  input  logic             pol_i,
  output logic             tdac_o
);
  logic [CNT_W-1:0] cnt;
  logic             sub_end, armed, raw, out_q;
  logic [SUB_W-1:0] wcoarse, wfine;

  tdac_counter #(.CNT_W(CNT_W), .POS_W(SUB_W)) u_cnt (
    .clk_i, .rst_ni, .cnt_o(cnt), .sub_end_o(sub_end)
  );

  tdac_latches #(.SUB_W(SUB_W)) u_lat (
    .clk_i, .rst_ni,
    .coarse_wr_i, .coarse_data_i, .fine_wr_i, .fine_data_i,
    .sub_end_i(sub_end),
    .work_coarse_o(wcoarse), .work_fine_o(wfine), .armed_o(armed)
  );

  tdac_pulse #(.SUB_W(SUB_W)) u_pul (
    .clk_i, .rst_ni, .cnt_i(cnt),
    .coarse_i(wcoarse), .fine_i(wfine), .raw_o(raw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= (armed & raw) ^ ~pol_i;
  end

  assign tdac_o = out_q;

  p_idle_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> (tdac_o == !$past(pol_i)));
endmodule

// File: tb/sim_tdac_pwm.sv
module sim_tdac_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int SUB_W      = 7;
  localparam int SUB_LEN    = 1 << SUB_W;
  localparam int FULL       = SUB_LEN * SUB_LEN;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             coarse_wr_i = 1'b0, fine_wr_i = 1'b0, pol_i = 1'b1;
  logic [SUB_W-1:0] coarse_data_i = '0, fine_data_i = '0;
  logic             tdac_o;

  tdac_pwm #(.SUB_W(SUB_W)) u0 (
    .clk_i, .rst_ni, .coarse_wr_i, .coarse_data_i,
    .fine_wr_i, .fine_data_i, .pol_i, .tdac_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int edges = 0, n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic int obs_c();
    return (edges - 1) % FULL;
  endfunction

  function automatic bit exp_raw(int c, int cv, int fv);
    int pos, k, tz;
    bit r;
    pos = c % SUB_LEN;
    k   = c / SUB_LEN;
    r   = (pos >= cv);
    if (pos == 0 && k != 0) begin
      tz = 0;
      while (((k >> tz) & 1) == 0) tz++;
      if (((fv >> (SUB_W - 1 - tz)) & 1) == 0) r = 1'b1;
    end
    return r;
  endfunction

  function automatic int exp_total(int cv, int fv, bit pol);
    int hi;
    hi = SUB_LEN * (SUB_LEN - cv) + ((cv > 0) ? (SUB_LEN - 1 - fv) : 0);
    return pol ? hi : FULL - hi;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
    edges++;
  endtask

  task automatic wr_coarse(int v);
    coarse_data_i = v[SUB_W-1:0];
    coarse_wr_i   = 1'b1;
    tick();
    coarse_wr_i   = 1'b0;
  endtask

  task automatic wr_fine(int v);
    fine_data_i = v[SUB_W-1:0];
    fine_wr_i   = 1'b1;
    tick();
    fine_wr_i   = 1'b0;
  endtask

  task automatic settle();
    repeat (3 * SUB_LEN) tick();
  endtask

  task automatic measure(output int hi);
    hi = 0;
    repeat (FULL) begin
      tick();
      hi += int'(tdac_o);
    end
  endtask

  initial begin
    int hi, bad, cv, fv;
    void'($urandom(32'd4711));
    #(3 * CLK_PERIOD + 2);
    check("R8 reset output", int'(tdac_o), 0);
    rst_ni = 1'b1;

    // R8 idle until first commit; R1/R6 commit lands at the boundary
    bad = 0;
    while (edges < 200) begin
      tick();
      if (tdac_o !== 1'b0) bad++;
    end
    check("R8 idle before commit", bad, 0);
    wr_coarse(0);
    wr_fine(SUB_LEN - 1);
    while (edges < 2 * SUB_LEN) tick();
    check("R6 still idle at position 127", int'(tdac_o), 0);
    tick();
    check("R1/R6 new word at position 0", int'(tdac_o), 1);

    // R3/R4 pulse map for 1111010 with coarse 127
    wr_coarse(SUB_LEN - 1);
    wr_fine(7'b1111010);
    settle();
    hi = 0;
    repeat (FULL) begin
      int c, pos;
      tick();
      c   = obs_c();
      pos = c % SUB_LEN;
      hi += int'(tdac_o);
      if (pos == 0)
        check((c == 0) ? "R4 sub-period 0 pulse" : "R3 fine pulse", int'(tdac_o),
              int'(exp_raw(c, SUB_LEN - 1, 7'b1111010)));
      else if (pos == 1)
        check("R2 coarse low after pulse", int'(tdac_o), 0);
    end
    check("R5 total 1111010", hi, exp_total(SUB_LEN - 1, 7'b1111010, 1'b1));

    // R5 random words
    for (int i = 0; i < 4; i++) begin
      cv = $urandom_range(SUB_LEN - 1, 0);
      fv = $urandom_range(SUB_LEN - 1, 0);
      wr_coarse(cv);
      wr_fine(fv);
      settle();
      measure(hi);
      check("R5 random total", hi, exp_total(cv, fv, 1'b1));
    end

    // R6 coarse-only write is held back
    wr_coarse(40);
    settle();
    measure(hi);
    check("R6 coarse-only write ignored", hi, exp_total(cv, fv, 1'b1));
    wr_fine(fv);
    settle();
    measure(hi);
    check("R6 fine write commits coarse", hi, exp_total(40, fv, 1'b1));

    // R7 inverted sense
    pol_i = 1'b0;
    tick();
    tick();
    measure(hi);
    check("R7 inverted total", hi, exp_total(40, fv, 1'b0));
    pol_i = 1'b1;

    // R5 end cases
    wr_coarse(0);
    wr_fine(0);
    settle();
    measure(hi);
    check("R5 coarse 0 fine hidden", hi, exp_total(0, 0, 1'b1));
    wr_coarse(SUB_LEN - 1);
    wr_fine(0);
    settle();
    measure(hi);
    check("R5 coarse 127 all fine", hi, exp_total(SUB_LEN - 1, 0, 1'b1));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (185000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule